// File: doc/BRIEF.md
# Square-root carry-select adder

This block adds two 20-bit unsigned operands and a carry-in. It returns a 20-bit sum and a carry-out. The operand bits are split into five slices whose widths grow by one bit from the least significant end: 2, 3, 4, 5 and 6 bits. The lowest slice ripples directly from the external carry-in.

Every higher slice forms per-bit generate and propagate terms first. It then runs two ripple chains side by side, one that assumes an incoming carry of 0 and one that assumes 1. The true carry leaving the slice below arrives later and steers a multiplexer. That multiplexer picks both the sum bits and the outgoing carry of the slice.

Because each slice is one bit wider than the one before it, the select signal and the local ripple of each slice settle at about the same moment. An optional output register, chosen by a parameter, lets the adder sit between flops for timing closure.

Top module: `csel_sqrt_adder`

## Requirements
- R1: With the output register disabled, {cout, sum} equals a + b + cin in the same cycle for every input, where cout is bit 20 of the 21-bit result.
- R2: The slice boundaries fall at bits 2, 5, 9 and 14. Slice widths are FIRST_W + index, and the defaults are FIRST_W = 2 and NUM_GRP = 5. A carry created below each boundary must reach the bit above it.
- R3: In every slice except the lowest, the candidate result computed for carry-in 1 equals the candidate for carry-in 0 plus one, taken as a (width+1)-bit value {carry, sum}.
- R4: When every bit of a slice propagates (a xor b all ones), the carry leaving that slice equals the carry entering it. Therefore all-ones plus zero with cin = 1 gives sum 0 and cout 1.
- R5: The lowest slice uses cin directly: a = 0, b = 0, cin = 1 gives sum 1 and cout 0, and zero plus zero with cin = 0 gives 0.
- R6: With REG_OUT = 1, sum and cout show the result one rising clock edge after the operands are applied. While rst_n is low they read 0.
- R7: Alternating patterns: 0xAAAAA + 0x55555 gives 0xFFFFF with cout 0 when cin = 0, and gives 0 with cout 1 when cin = 1.
- R8: In every non-lowest slice, the carry-out of the carry-in-0 chain is never 1 while the carry-out of the carry-in-1 chain is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| a | input | 20 | First operand |
| b | input | 20 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 20 | Sum bits |
| cout | output | 1 | Carry out of bit 19 |

## Verification
The bench builds the adder twice with the default partition (FIRST_W = 2, NUM_GRP = 5). Instance `dut` has REG_OUT = 1 and instance `dut_c` has REG_OUT = 0. This lets one stimulus stream check the same-cycle combinational result and the one-edge registered result, including the cleared outputs during reset. Directed operands are chosen to push a carry across each of the four slice boundaries and to make a full propagate run through every slice. Random operands then exercise both candidate chains and the select multiplexers together.

// File: rtl/csel_pkg.sv
package csel_pkg;

    // lowest bit index of slice g when slice widths are first_w, first_w+1, ...
    function automatic int grp_lo(input int first_w, input int g);
        return g * first_w + (g * (g - 1)) / 2;
    endfunction

    function automatic int grp_w(input int first_w, input int g);
        return first_w + g;
    endfunction

    function automatic int total_w(input int first_w, input int n);
        return grp_lo(first_w, n);
    endfunction

endpackage

// File: rtl/csel_pg.sv
module csel_pg #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] gen,
    output logic [W-1:0] prop
);
    always_comb begin
        gen  = a & b;
        prop = a ^ b;
    end
endmodule

// File: rtl/csel_ripple.sv
module csel_ripple #(
    parameter int W = 4
) (
    input  logic [W-1:0] gen,
    input  logic [W-1:0] prop,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         co
);
    logic [W:0] c;

    assign c[0] = ci;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign c[i+1] = gen[i] | (prop[i] & c[i]);
        assign s[i]   = prop[i] ^ c[i];
    end

    assign co = c[W];
endmodule

// File: rtl/csel_group.sv
module csel_group #(
    parameter int W    = 4,
    parameter bit DUAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         co
);
    logic [W-1:0] gen, prop;

    csel_pg #(.W(W)) u_pg (
        .a    (a),
        .b    (b),
        .gen  (gen),
        .prop (prop)
    );

    if (DUAL) begin : g_dual
        logic [W-1:0] s0, s1;
        logic         co0, co1;

        csel_ripple #(.W(W)) u_chain0 (
            .gen  (gen),
            .prop (prop),
            .ci   (1'b0),
            .s    (s0),
            .co   (co0)
        );

        csel_ripple #(.W(W)) u_chain1 (
            .gen  (gen),
            .prop (prop),
            .ci   (1'b1),
            .s    (s1),
            .co   (co1)
        );

        always_comb begin
            unique case (ci)
                1'b0: begin s = s0; co = co0; end
                1'b1: begin s = s1; co = co1; end
                default: begin s = s0; co = co0; end
            endcase
        end

        // R3
        cand_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            {co1, s1} == ({co0, s0} + (W+1)'(1)));

        // R8
        cand_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            co0 |-> co1);
    end else begin : g_single
        csel_ripple #(.W(W)) u_chain (
            .gen  (gen),
            .prop (prop),
            .ci   (ci),
            .s    (s),
            .co   (co)
        );
    end

    // R4
    full_prop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&prop) |-> (co == ci));
endmodule

// File: rtl/csel_sqrt_adder.sv
module csel_sqrt_adder
    import csel_pkg::*;
#(
    parameter int FIRST_W = 2,
    parameter int NUM_GRP = 5,
    parameter bit REG_OUT = 1'b1,
    localparam int W      = total_w(FIRST_W, NUM_GRP)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [NUM_GRP:0] gcarry;
    logic [W-1:0]     sum_c;

    assign gcarry[0] = cin;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_slice
        localparam int LO = grp_lo(FIRST_W, g);
        localparam int GW = grp_w(FIRST_W, g);

        csel_group #(.W(GW), .DUAL(g != 0)) u_grp (
            .clk   (clk),
            .rst_n (rst_n),
            .a     (a[LO +: GW]),
            .b     (b[LO +: GW]),
            .ci    (gcarry[g]),
            .s     (sum_c[LO +: GW]),
            .co    (gcarry[g+1])
        );
    end

    logic [W:0] ref_now;
    assign ref_now = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};

    if (REG_OUT) begin : g_reg
        logic valid_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sum     <= '0;
                cout    <= 1'b0;
                valid_q <= 1'b0;
            end else begin
                sum     <= sum_c;
                cout    <= gcarry[NUM_GRP];
                valid_q <= 1'b1;
            end
        end

        // R6
        reg_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
            valid_q |-> ({cout, sum} == $past(ref_now)));
    end else begin : g_comb
        assign sum  = sum_c;
        assign cout = gcarry[NUM_GRP];

        // R1
        comb_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
            {cout, sum} == ref_now);
    end
endmodule

// File: tb/tb_csel_sqrt_adder.sv
module tb_csel_sqrt_adder;
    localparam int CLK_P = 10;
    localparam int W     = 20;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a = '0, b = '0;
    logic         cin = 1'b0;
    logic [W-1:0] sum_r, sum_c;
    logic         cout_r, cout_c;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    csel_sqrt_adder #(.FIRST_W(2), .NUM_GRP(5), .REG_OUT(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .a(a), .b(b), .cin(cin),
        .sum(sum_r), .cout(cout_r)
    );

    csel_sqrt_adder #(.FIRST_W(2), .NUM_GRP(5), .REG_OUT(1'b0)) dut_c (
        .clk(clk), .rst_n(rst_n), .a(a), .b(b), .cin(cin),
        .sum(sum_c), .cout(cout_c)
    );

    task automatic chk(input bit ok, input string req, input logic [W:0] act, input logic [W:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at negedge, check comb after settle, registered after next edge
    task automatic apply(input logic [W-1:0] ta, input logic [W-1:0] tb, input logic tc, input string req);
        logic [W:0] exp;
        exp = {1'b0, ta} + {1'b0, tb} + {{W{1'b0}}, tc};
        @(negedge clk);
        a = ta; b = tb; cin = tc;
        #1;
        chk({cout_c, sum_c} == exp, {req, " R1 comb"}, {cout_c, sum_c}, exp);
        @(posedge clk);
        #1;
        chk({cout_r, sum_r} == exp, {req, " R6 reg"}, {cout_r, sum_r}, exp);
    endtask

    task automatic t_reset;
        a = 20'hABCDE; b = 20'h12345; cin = 1'b1;
        repeat (3) @(negedge clk);
        chk({cout_r, sum_r} == '0, "R6 reset", {cout_r, sum_r}, '0);
        rst_n = 1'b1;
    endtask

    task automatic t_first_slice;
        apply(20'h0, 20'h0, 1'b1, "R5 cin only");
        apply(20'h0, 20'h0, 1'b0, "R5 zero");
    endtask

    task automatic t_boundaries;
        int edges [4] = '{2, 5, 9, 14};
        foreach (edges[i]) begin
            apply((20'h1 << edges[i]) - 20'h1, 20'h1, 1'b0, "R2 boundary");
            apply((20'h1 << (edges[i] - 1)), (20'h1 << (edges[i] - 1)), 1'b0, "R2 gen edge");
        end
    endtask

    task automatic t_propagate;
        apply(20'hFFFFF, 20'h0, 1'b1, "R4 ones+cin");
        apply(20'hFFFFF, 20'h1, 1'b0, "R4 ones+1");
        apply(20'hF0F0F, 20'h0F0F0, 1'b1, "R4 split prop");
    endtask

    task automatic t_alternate;
        apply(20'hAAAAA, 20'h55555, 1'b0, "R7 alt c0");
        apply(20'hAAAAA, 20'h55555, 1'b1, "R7 alt c1");
        apply(20'hAAAAA, 20'hAAAAA, 1'b0, "R7 alt same");
    endtask

    task automatic t_random;
        for (int i = 0; i < 300; i++)
            apply(W'($urandom), W'($urandom), 1'($urandom), "R3 R8 random");
    endtask

    initial begin
        t_reset();
        t_first_slice();
        t_boundaries();
        t_propagate();
        t_alternate();
        t_random();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule